// File: doc/BRIEF.md
# Negate Unit with Status Flags

This block is the execution slice for a two's complement negate. Each cycle it can accept one decoded operation: an opcode byte, the three-bit extension field taken from the addressing byte, and the prefix state. That state is a lock indication, an operand-size override, a 64-bit width bit, and a flag that says the core runs in 64-bit mode. The operand arrives already fetched, and a separate input says whether the destination lies in memory. From these inputs the unit picks an operand width of 8, 16, 32 or 64 bits. It computes zero minus the operand at that width and produces six status flags with the values a subtraction from zero would give.

Illegal encodings are trapped. Examples are a lock prefix on a register destination, the 64-bit width bit outside 64-bit mode, or an opcode that is not this operation. A trapped operation gives an invalid indication and no result. The result, the flags and both indications are registered, and they appear one clock after the operation is presented. Address generation, memory access, bus locking and register writeback belong to other blocks.

Top module: `neg_unit`

## Requirements
- R1: An accepted operation (`in_valid` high and legal) gives `out_valid` high for exactly one cycle, one clock later, with `result` equal to zero minus the operand at the selected width.
- R2: Opcode 0xF6 with `ext_field` 3 selects 8 bits. Opcode 0xF7 with `ext_field` 3 selects 32 bits by default and 16 bits with `opsize_pfx`. When `long_mode` and `wide_bit` are both set it selects 64 bits, and this overrides `opsize_pfx`.
- R3: `flags[5]` (overflow) is set exactly when the operand at the selected width is the most negative value of that width.
- R4: `flags[0]` (carry) is clear when the operand at the selected width is zero and set otherwise.
- R5: `flags[4]` (sign) equals the top bit of the result at the selected width. `flags[3]` (zero) is set when the result at the selected width is zero.
- R6: `flags[2]` (auxiliary carry) is set when the low four bits of the operand are nonzero.
- R7: `flags[1]` (parity) is set when the low 8 bits of the result hold an even number of ones, whatever the width.
- R8: For the 8 and 16-bit forms, the result bits above the width copy the operand. For the 32-bit form they are zero.
- R9: `lock_pfx` with a register destination (`dst_is_mem` low) gives `out_invalid` high and `out_valid` low one clock later. `result` and `flags` keep their earlier values.
- R10: Opcode 0xF7 with `wide_bit` set while `long_mode` is clear is trapped in the same way as R9.
- R11: Any opcode other than 0xF6 or 0xF7, or an `ext_field` other than 3, is trapped in the same way as R9.
- R12: Synchronous active-high reset clears `out_valid`, `out_invalid`, `result` and `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| opcode | input | 8 | Primary opcode byte |
| ext_field | input | 3 | Opcode extension field of the addressing byte |
| lock_pfx | input | 1 | Lock prefix present |
| opsize_pfx | input | 1 | Operand-size override prefix present |
| wide_bit | input | 1 | 64-bit operand width bit |
| long_mode | input | 1 | Core is in 64-bit mode |
| dst_is_mem | input | 1 | Destination is a memory operand |
| operand | input | 64 | Destination value before the operation |
| out_valid | output | 1 | Result and flags updated this cycle |
| out_invalid | output | 1 | Presented operation was trapped as invalid |
| result | output | 64 | Negated destination value |
| flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
Every output is due exactly one rising edge after the operation is presented: `out_valid`, `out_invalid`, `result` and `flags` all change on that edge together. The bench drives inputs on the falling edge and drops `in_valid` on the next falling edge. It samples at that same falling edge, which is half a period after the edge that captured the operation. For trapped operations it also compares `result` and `flags` with the values captured from the previous accepted operation. This shows at the ports that nothing was written.

// File: rtl/neg_pkg.sv
package neg_pkg;

    localparam int DATA_W  = 64;
    localparam int FLAG_W  = 6;
    localparam int NIB_W   = 4;
    localparam int PAR_W   = 8;

    localparam logic [7:0] OPC_BYTE = 8'hF6;
    localparam logic [7:0] OPC_FULL = 8'hF7;
    localparam logic [2:0] EXT_NEG  = 3'd3;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } width_e;

    // bit 5 down to bit 0
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    function automatic logic [DATA_W-1:0] width_mask(input width_e w);
        case (w)
            WID_8:   width_mask = DATA_W'({8{1'b1}});
            WID_16:  width_mask = DATA_W'({16{1'b1}});
            WID_32:  width_mask = DATA_W'({32{1'b1}});
            default: width_mask = {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_top(input width_e w);
        logic [DATA_W-1:0] m;
        m = width_mask(w);
        width_top = m & ~(m >> 1);
    endfunction

endpackage

// File: rtl/neg_decode.sv
module neg_decode
    import neg_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [2:0] ext_field,
    input  logic       lock_pfx,
    input  logic       opsize_pfx,
    input  logic       wide_bit,
    input  logic       long_mode,
    input  logic       dst_is_mem,
    output width_e     width,
    output logic       illegal
);

    logic is_byte, is_full, bad_lock, bad_wide;

    always_comb begin
        is_byte  = (opcode == OPC_BYTE) && (ext_field == EXT_NEG);
        is_full  = (opcode == OPC_FULL) && (ext_field == EXT_NEG);
        bad_lock = lock_pfx && !dst_is_mem;
        bad_wide = is_full && wide_bit && !long_mode;
        illegal  = !(is_byte || is_full) || bad_lock || bad_wide;

        if (is_byte)                    width = WID_8;
        else if (long_mode && wide_bit) width = WID_64;
        else if (opsize_pfx)            width = WID_16;
        else                            width = WID_32;
    end

endmodule

// File: rtl/neg_core.sv
module neg_core
    import neg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] operand,
    input  width_e       width,
    output logic [W-1:0] result,
    output flags_t       flags
);

    logic [W-1:0] mask, top, opw, negw, keep;

    always_comb begin
        mask = W'(width_mask(width));
        top  = W'(width_top(width));
        opw  = operand & mask;
        negw = ({W{1'b0}} - opw) & mask;
        keep = (width == WID_32) ? {W{1'b0}} : (operand & ~mask);
        result = keep | negw;

        flags.cry = |opw;
        flags.ovf = (opw == top);
        flags.sgn = |(negw & top);
        flags.zro = (negw == {W{1'b0}});
        flags.aux = |operand[NIB_W-1:0];
        flags.par = ~^negw[PAR_W-1:0];
    end

endmodule

// File: rtl/neg_unit.sv
module neg_unit
    import neg_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    opcode,
    input  logic [2:0]    ext_field,
    input  logic          lock_pfx,
    input  logic          opsize_pfx,
    input  logic          wide_bit,
    input  logic          long_mode,
    input  logic          dst_is_mem,
    input  logic [W-1:0]  operand,
    output logic          out_valid,
    output logic          out_invalid,
    output logic [W-1:0]  result,
    output logic [FW-1:0] flags
);

    width_e       width;
    logic         illegal;
    logic [W-1:0] res_c;
    flags_t       flg_c;

    neg_decode u_dec (
        .opcode     (opcode),
        .ext_field  (ext_field),
        .lock_pfx   (lock_pfx),
        .opsize_pfx (opsize_pfx),
        .wide_bit   (wide_bit),
        .long_mode  (long_mode),
        .dst_is_mem (dst_is_mem),
        .width      (width),
        .illegal    (illegal)
    );

    neg_core #(.W(W)) u_core (
        .operand (operand),
        .width   (width),
        .result  (res_c),
        .flags   (flg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_invalid <= 1'b0;
            result      <= '0;
            flags       <= '0;
        end else begin
            out_valid   <= in_valid && !illegal;
            out_invalid <= in_valid && illegal;
            if (in_valid && !illegal) begin
                result <= res_c;
                flags  <= FW'(flg_c);
            end
        end
    end

    // R1: a legal operation yields a valid result on the next cycle
    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !illegal) |=> out_valid);

    // R9: trap and valid never together; trapped ops leave state untouched
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> ($stable(result) && $stable(flags)));
    p_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lock_pfx && !dst_is_mem) |=> out_invalid);

    // R10: 64-bit width outside 64-bit mode traps
    p_wide_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OPC_FULL && wide_bit && !long_mode) |=> out_invalid);

    // R4: carry is set exactly when the result is nonzero
    p_cry_zro_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[0] != flags[3]));

    // R3: the most negative value negates to itself, so sign stays set
    p_ovf_sgn_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[5]) |-> flags[4]);

    // R6: a zero result means a zero operand, hence no nibble borrow
    p_zro_aux_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[3]) |-> !flags[2]);

endmodule

// File: tb/neg_unit_tb_top.sv
module neg_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [2:0]  ext_field;
    logic        lock_pfx, opsize_pfx, wide_bit, long_mode, dst_is_mem;
    logic [63:0] operand;
    logic        out_valid, out_invalid;
    logic [63:0] result;
    logic [5:0]  flags;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    neg_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .ext_field(ext_field), .lock_pfx(lock_pfx), .opsize_pfx(opsize_pfx),
        .wide_bit(wide_bit), .long_mode(long_mode), .dst_is_mem(dst_is_mem),
        .operand(operand), .out_valid(out_valid), .out_invalid(out_invalid),
        .result(result), .flags(flags)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected {flags, result} from the arithmetic definition
    function automatic logic [69:0] model(input logic [63:0] op, input int w);
        logic [63:0] mask, top, low, n, res;
        logic of, sf, zf, af, pf, cf;
        int ones;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        top  = 64'd1 << (w - 1);
        low  = op & mask;
        n    = (64'd0 - low) & mask;
        res  = (w == 32) ? n : ((op & ~mask) | n);
        ones = 0;
        for (int b = 0; b < 8; b++) ones += int'(n[b]);
        of = (low == top);
        sf = (n & top) != 0;
        zf = (n == 0);
        af = (op[3:0] != 0);
        pf = (ones % 2 == 0);
        cf = (low != 0);
        return {of, sf, zf, af, pf, cf, res};
    endfunction

    task automatic issue(input logic [7:0] opc, input logic [2:0] ext, input logic lk,
                         input logic osz, input logic wb, input logic lm,
                         input logic mem, input logic [63:0] op);
        @(negedge clk);
        in_valid = 1'b1; opcode = opc; ext_field = ext; lock_pfx = lk;
        opsize_pfx = osz; wide_bit = wb; long_mode = lm; dst_is_mem = mem;
        operand = op;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic legal_op(input string req, input logic [7:0] opc, input logic osz,
                            input logic wb, input logic lm, input logic [63:0] op, input int w);
        logic [69:0] e;
        issue(opc, 3'd3, 1'b0, osz, wb, lm, 1'b1, op);
        e = model(op, w);
        chk({req, " R1 valid"}, 64'(out_valid), 64'd1);
        chk({req, " R1 R2 R8 result"}, result, e[63:0]);
        chk({req, " R3 R4 R5 R6 R7 flags"}, 64'(flags), 64'(e[69:64]));
    endtask

    task automatic trap_op(input string req, input logic [7:0] opc, input logic [2:0] ext,
                           input logic lk, input logic wb, input logic lm, input logic mem);
        logic [63:0] pr;
        logic [5:0]  pf;
        pr = result; pf = flags;
        issue(opc, ext, lk, 1'b0, wb, lm, mem, 64'h1234_5678_9ABC_DEF1);
        chk({req, " invalid"}, 64'(out_invalid), 64'd1);
        chk({req, " no valid"}, 64'(out_valid), 64'd0);
        chk({req, " result held"}, result, pr);
        chk({req, " flags held"}, 64'(flags), 64'(pf));
    endtask

    initial begin
        logic [63:0] r;
        rst = 1'b1; in_valid = 1'b0; opcode = '0; ext_field = '0; lock_pfx = 0;
        opsize_pfx = 0; wide_bit = 0; long_mode = 0; dst_is_mem = 0; operand = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 valid", 64'(out_valid), 64'd0);
        chk("R12 invalid", 64'(out_invalid), 64'd0);
        chk("R12 result", result, 64'd0);
        chk("R12 flags", 64'(flags), 64'd0);

        // R2 byte form, exhaustive low byte, random upper bits (R8 pass-through)
        for (int i = 0; i < 256; i++) begin
            r = {$urandom, $urandom};
            legal_op("byte", 8'hF6, 1'b0, 1'b0, 1'b1, {r[63:8], 8'(i)}, 8);
        end
        // byte form ignores width bit and override
        legal_op("byte wide R2", 8'hF6, 1'b1, 1'b1, 1'b1, 64'hFFFF_0000_0000_0080, 8);

        // R2 16-bit via override, strided sweep plus corners
        for (int i = 0; i < 65536; i += 509) begin
            r = {$urandom, $urandom};
            legal_op("word", 8'hF7, 1'b1, 1'b0, 1'b1, {r[63:16], 16'(i)}, 16);
        end
        legal_op("word zero", 8'hF7, 1'b1, 1'b0, 1'b0, 64'hABCD_0000_0000_0000, 16);
        legal_op("word minneg", 8'hF7, 1'b1, 1'b0, 1'b1, 64'h0000_1111_2222_8000, 16);
        legal_op("word ones", 8'hF7, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_FFFF, 16);

        // R2 32-bit default in and out of 64-bit mode, R8 upper zero
        legal_op("dword zero", 8'hF7, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_0000_0000, 32);
        legal_op("dword minneg", 8'hF7, 1'b0, 1'b0, 1'b1, 64'h5555_5555_8000_0000, 32);
        legal_op("dword legacy", 8'hF7, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 32);
        for (int i = 0; i < 200; i++) begin
            legal_op("dword rnd", 8'hF7, 1'b0, 1'b0, 1'b1, {$urandom, $urandom}, 32);
        end

        // R2 64-bit, width bit overrides the size prefix
        legal_op("qword zero", 8'hF7, 1'b0, 1'b1, 1'b1, 64'd0, 64);
        legal_op("qword minneg", 8'hF7, 1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64);
        legal_op("qword prec", 8'hF7, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0001_0000, 64);
        for (int i = 0; i < 200; i++) begin
            legal_op("qword rnd", 8'hF7, 1'b0, 1'b1, 1'b1, {$urandom, $urandom}, 64);
        end

        // R9 lock with register destination; lock with memory is legal
        legal_op("pre trap", 8'hF7, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0005, 64);
        trap_op("R9 lock reg", 8'hF7, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        trap_op("R9 lock reg byte", 8'hF6, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        begin
            logic [69:0] e;
            issue(8'hF6, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0042);
            e = model(64'h42, 8);
            chk("R9 lock mem valid", 64'(out_valid), 64'd1);
            chk("R9 lock mem result", result, e[63:0]);
        end
        // R10 width bit outside 64-bit mode
        trap_op("R10 wide legacy", 8'hF7, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        // R11 foreign encodings
        trap_op("R11 opcode", 8'hF5, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        trap_op("R11 ext", 8'hF7, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        trap_op("R11 ext byte", 8'hF6, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1);

        // R1 single-cycle pulse
        @(negedge clk);
        chk("R1 pulse ends", 64'(out_valid), 64'd0);
        chk("R9 trap ends", 64'(out_invalid), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule